// File: doc/BRIEF.md
# Transmit Controller Step Guard

This block is a synthesizable runtime checker that sits beside a four-state transmit controller and watches its state code. Each cycle in which the qualifier is high, it compares the newly reported state with the previously reported one against a fixed allow-list. A step outside that list, or a code that is not one of the four defined states, is reported as possible hidden or inserted behaviour. Such behaviour can come from an extra state that a malicious edit has added to the controller.

The guard keeps a sticky flag that stays set until reset. It also raises a one-cycle pulse for every offending sample, and it holds the previous and next codes of the first offending step for later inspection. The code width is a parameter, so a wider port can carry encodings beyond the four legal ones. This models a controller that has grown extra state bits.

Top module: `step_guard`

## Requirements
- R1: After reset (active-low `rstN`), `violSticky`, `violPulse`, `violPrev` and `violNext` are all zero.
- R2: The legal codes are idle=0, load=1, shift=2 and stop=3. Reporting the same legal code on consecutive valid samples is never a violation.
- R3: The forward steps idle to load, load to shift, shift to stop and stop to idle are never a violation.
- R4: Any other step between two legal codes is a violation. Examples are idle to shift, stop to load, load to stop, stop to shift and idle to stop.
- R5: A valid sample whose code is 4 or more is a violation, even on the first valid sample after reset. A valid step whose previous code was 4 or more is also a violation.
- R6: The first valid sample after reset has no predecessor. It is not checked as a step, so a legal code there is never a violation.
- R7: Cycles with `stateValid` low are ignored. They neither raise a violation nor replace the stored previous code, so the next valid sample is compared with the last valid one.
- R8: `violPulse` is high for exactly the one cycle after the clock edge that sampled an offending code. Back-to-back offending samples give back-to-back pulses.
- R9: `violSticky` rises together with the first pulse and stays high until reset, whatever follows.
- R10: On the first violation, `violPrev` takes the previous valid code (0 if there was none since reset) and `violNext` takes the offending code. Both then hold through later violations until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stateCode | input | CODE_W | State code reported by the watched controller |
| stateValid | input | 1 | High when `stateCode` is to be sampled |
| violSticky | output | 1 | Set on the first violation, held until reset |
| violPulse | output | 1 | One-cycle pulse per offending sample |
| violPrev | output | CODE_W | Previous code of the first offending step |
| violNext | output | CODE_W | Offending code of the first offending step |

## Verification
The bench builds the guard with `CODE_W` set to 3, which makes the codes 4 through 7 reachable. This lets it drive unknown encodings on the first sample, in the middle of a run and as the source of a step. With the default width of 2, every code is legal, and only the illegal-step checks of R4 could be exercised. It also sends garbage codes with the qualifier low, to show they leave both the comparison and the outputs untouched.

// File: rtl/step_guard_pkg.sv
package step_guard_pkg;

  localparam int NUM_STATES = 4;
  localparam int BASE_W     = 2;

  // Legal controller states; the forward order is a ring
  typedef enum logic [BASE_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } txState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeSample;   // store current code as the new previous code
    logic raiseViol;    // current sample is an offending one
  } guardStrobe_t;

endpackage

// File: rtl/step_guard_ctrl.sv
module step_guard_ctrl
  import step_guard_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stateValid,
  input  logic [CODE_W-1:0] curCode,
  input  logic [CODE_W-1:0] prevCode,
  output guardStrobe_t      strobe
);

  localparam int EXT_W = CODE_W + 1;

  logic havePrev;
  logic curKnown;
  logic stepOk;

  function automatic logic isKnown(input logic [CODE_W-1:0] code);
    return {1'b0, code} < EXT_W'(NUM_STATES);
  endfunction

  function automatic txState_e succOf(input txState_e s);
    txState_e n;
    unique case (s)
      ST_IDLE:  n = ST_LOAD;
      ST_LOAD:  n = ST_SHIFT;
      ST_SHIFT: n = ST_STOP;
      ST_STOP:  n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic isPermitted(input logic [CODE_W-1:0] p,
                                       input logic [CODE_W-1:0] c);
    txState_e ps;
    txState_e cs;
    ps = txState_e'(p[BASE_W-1:0]);
    cs = txState_e'(c[BASE_W-1:0]);
    return isKnown(p) && isKnown(c) && ((cs == ps) || (cs == succOf(ps)));
  endfunction

  always_comb begin
    curKnown          = isKnown(curCode);
    stepOk            = isPermitted(prevCode, curCode);
    strobe.takeSample = stateValid;
    strobe.raiseViol  = stateValid && (!curKnown || (havePrev && !stepOk));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           havePrev <= 1'b0;
    else if (stateValid) havePrev <= 1'b1;
  end

  // R4: a skip from idle straight to shift must be raised
  a_r4_skip_raised: assert property (@(posedge clk) disable iff (!rstN)
    (havePrev && stateValid && prevCode == CODE_W'(0) && curCode == CODE_W'(2))
      |-> strobe.raiseViol);

  // R3: wrap from stop back to idle is clean
  a_r3_wrap_clean: assert property (@(posedge clk) disable iff (!rstN)
    (havePrev && stateValid && prevCode == CODE_W'(3) && curCode == CODE_W'(0))
      |-> !strobe.raiseViol);

  // R6: the first valid legal sample is never raised
  a_r6_first_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!havePrev && stateValid && curCode == CODE_W'(2)) |-> !strobe.raiseViol);

endmodule

// File: rtl/step_guard_dp.sv
module step_guard_dp
  import step_guard_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] stateCode,
  input  guardStrobe_t      strobe,
  output logic [CODE_W-1:0] prevCode,
  output logic              violSticky,
  output logic              violPulse,
  output logic [CODE_W-1:0] violPrev,
  output logic [CODE_W-1:0] violNext
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode   <= '0;
      violSticky <= 1'b0;
      violPulse  <= 1'b0;
      violPrev   <= '0;
      violNext   <= '0;
    end else begin
      violPulse <= strobe.raiseViol;
      if (strobe.takeSample) prevCode <= stateCode;
      if (strobe.raiseViol) begin
        violSticky <= 1'b1;
        if (!violSticky) begin
          violPrev <= prevCode;
          violNext <= stateCode;
        end
      end
    end
  end

  // R9: sticky flag never drops before reset
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    violSticky |=> violSticky);

  // R8: any pulse is accompanied by the sticky flag
  a_r8_pulse_sticky: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> violSticky);

  // R10: captured codes are frozen once the flag is set
  a_r10_capture_frozen: assert property (@(posedge clk) disable iff (!rstN)
    violSticky |=> ($stable(violPrev) && $stable(violNext)));

endmodule

// File: rtl/step_guard.sv
module step_guard
  import step_guard_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] stateCode,
  input  logic              stateValid,
  output logic              violSticky,
  output logic              violPulse,
  output logic [CODE_W-1:0] violPrev,
  output logic [CODE_W-1:0] violNext
);

  localparam int EXT_W = CODE_W + 1;

  guardStrobe_t      strobe;
  logic [CODE_W-1:0] prevCode;

  step_guard_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stateValid (stateValid),
    .curCode    (stateCode),
    .prevCode   (prevCode),
    .strobe     (strobe)
  );

  step_guard_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stateCode  (stateCode),
    .strobe     (strobe),
    .prevCode   (prevCode),
    .violSticky (violSticky),
    .violPulse  (violPulse),
    .violPrev   (violPrev),
    .violNext   (violNext)
  );

  // R5: an unknown code on a valid cycle pulses on the next cycle
  a_r5_unknown_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (stateValid && ({1'b0, stateCode} >= EXT_W'(NUM_STATES))) |=> violPulse);

  // R7: a cycle with the qualifier low never produces a pulse
  a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !stateValid |=> !violPulse);

endmodule

// File: tb/step_guard_tb.sv
module step_guard_tb;

  localparam int CW = 3;
  typedef logic [2*CW+1:0] exp_t;

  logic          clk = 1'b0;
  logic          rstN;
  logic [CW-1:0] stateCode;
  logic          stateValid;
  logic          violSticky, violPulse;
  logic [CW-1:0] violPrev, violNext;

  always #4 clk = ~clk;

  step_guard #(.CODE_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .stateCode(stateCode), .stateValid(stateValid),
    .violSticky(violSticky), .violPulse(violPulse),
    .violPrev(violPrev), .violNext(violNext)
  );

  int checks = 0;
  int fails  = 0;

  exp_t  expQ[$];
  string tagQ[$];

  // reference model state
  logic [CW-1:0] mPrev, mCapP, mCapN;
  logic          mHave, mSticky;

  function automatic bit known(input logic [CW-1:0] c);
    return int'(c) < 4;
  endfunction

  function automatic bit permitted(input logic [CW-1:0] p, input logic [CW-1:0] c);
    return known(p) && known(c) &&
           ((int'(c) == int'(p)) || (int'(c) == ((int'(p) + 1) % 4)));
  endfunction

  task automatic modelReset();
    mPrev = '0; mCapP = '0; mCapN = '0; mHave = 1'b0; mSticky = 1'b0;
  endtask

  // driver: applies one sample and pushes the expected outputs
  task automatic drive(input int code, input bit valid, input string tag);
    bit bad;
    @(negedge clk);
    stateCode  = CW'(code);
    stateValid = valid;
    bad = 1'b0;
    if (valid) begin
      bad = !known(CW'(code)) || (mHave && !permitted(mPrev, CW'(code)));
      if (bad && !mSticky) begin
        mCapP = mPrev;
        mCapN = CW'(code);
      end
      if (bad) mSticky = 1'b1;
      mPrev = CW'(code);
      mHave = 1'b1;
    end
    expQ.push_back({bad, mSticky, mCapP, mCapN});
    tagQ.push_back(tag);
  endtask

  // monitor: compares after each active edge
  exp_t  monExp;
  exp_t  monAct;
  string monTag;
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      monExp = expQ.pop_front();
      monTag = tagQ.pop_front();
      monAct = {violPulse, violSticky, violPrev, violNext};
      checks++;
      if (monAct !== monExp) begin
        fails++;
        $display("FAIL %s: got pulse=%b sticky=%b prev=%0d next=%0d, expected pulse=%b sticky=%b prev=%0d next=%0d",
                 monTag, monAct[2*CW+1], monAct[2*CW], monAct[2*CW-1:CW], monAct[CW-1:0],
                 monExp[2*CW+1], monExp[2*CW], monExp[2*CW-1:CW], monExp[CW-1:0]);
      end
    end
  end

  task automatic checkResetState();
    checks++;
    if ({violPulse, violSticky, violPrev, violNext} !== '0) begin
      fails++;
      $display("FAIL R1: got pulse=%b sticky=%b prev=%0d next=%0d, expected all zero",
               violPulse, violSticky, violPrev, violNext);
    end
  endtask

  task automatic doReset();
    wait (expQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    stateValid = 1'b0;
    repeat (2) @(negedge clk);
    checkResetState();  // R1
    modelReset();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; stateValid = 1'b0; stateCode = '0;
    modelReset();
    repeat (3) @(negedge clk);
    checkResetState();  // R1
    rstN = 1'b1;

    // R6 first sample, R2 holds, R3 forward steps
    drive(0, 1, "R6"); drive(0, 1, "R2"); drive(1, 1, "R3"); drive(1, 1, "R2");
    drive(2, 1, "R3"); drive(3, 1, "R3"); drive(3, 1, "R2"); drive(0, 1, "R3");
    drive(1, 1, "R3");
    // R7: gaps with garbage codes are ignored
    drive(6, 0, "R7"); drive(0, 0, "R7"); drive(2, 1, "R7");
    drive(5, 0, "R7"); drive(3, 1, "R7");
    // R4 stop->load, then R8 back-to-back, R10 capture holds
    drive(1, 1, "R4"); drive(0, 1, "R8"); drive(0, 1, "R8");
    drive(2, 1, "R4");
    // R9 sticky through clean cycles
    drive(2, 1, "R9"); drive(3, 1, "R9"); drive(2, 0, "R9"); drive(0, 1, "R10");
    doReset();

    // R5 unknown code on first sample, repeated, and as step source
    drive(5, 1, "R5"); drive(5, 1, "R5"); drive(0, 1, "R5"); drive(1, 1, "R5");
    doReset();

    drive(2, 1, "R6"); drive(7, 1, "R5"); drive(3, 1, "R5");
    doReset();

    // R4 other illegal steps
    drive(1, 1, "R4"); drive(3, 1, "R4"); drive(0, 1, "R4");
    drive(3, 1, "R4"); drive(2, 1, "R4");
    doReset();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule